// File: doc/BRIEF.md
# Board interrupt aggregator and control registers

This block gathers thirteen level-sensitive interrupt lines from board devices, samples them into a 16-bit status word and gates that word with a mask that software can write. From the sources that are both active and enabled, it selects the one with the numerically lowest priority level. It then presents that level, inverted, as a 4-bit encoded interrupt request toward the processor.

The same 16-bit register port also holds three other registers. The first is a general-purpose output register whose value drives pins. The second is a read-only version register. The third is a power-off register: a write to it with bit 0 set produces a one-cycle shutdown request.

Accesses are synchronous and one per cycle. The port carries byte addresses within a 64-byte window, and only 16-bit accesses are supported.

Top module: `board_ctl`

## Requirements
- R1: Source input k sets status bit P(k) one clock after it is sampled, and that bit follows the input level. For k = 0..12 the bit positions P are 9, 8, 14, 13, 12, 11, 10, 6, 5, 4, 7, 0, 15. Status bits 1, 2 and 3 stay 0.
- R2: Source k is pending only when status bit P(k) and mask bit P(k) are both 1. A masked source has no effect on `irl_o`.
- R3: For k = 0..12 the priority levels L are 1, 2, 9, 10, 3, 0, 4, 5, 6, 7, 8, 11, 12. Among pending sources the smallest level wins, and `irl_o` = level XOR 15. With nothing pending `irl_o` is 0, and a level-0 source gives 15.
- R4: `irl_o` reflects a change on a source input, or a write to the mask, one clock after the edge that samples it.
- R5: The mask register is at byte offset 0x00. It is read/write and reads return the last value written.
- R6: The output-port register is at offset 0x36. It is read/write, drives `out_port_o`, and holds its value until it is written again.
- R7: A write to offset 0x30 with `wdata_i[0]`=1 gives a `pwr_off_o` pulse exactly one clock long in the following cycle. A write to 0x30 with bit 0 clear gives no pulse, and reads of 0x30 return 0.
- R8: Offset 0x32 always reads 0x0010, and writes to it are ignored.
- R9: Any other offset, including every odd byte address, reads 0, and writes to it change nothing.
- R10: Reset (`rst_ni` low) clears the mask, the output port, the status bits and `rdata_o`. It also drives `irl_o` and `pwr_off_o` to 0.
- R11: Read data appears on `rdata_o` one clock after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 13 | Interrupt source levels, index k as in R1/R3 |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset in the register window |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irl_o | output | 4 | Encoded interrupt level toward the CPU |
| out_port_o | output | 16 | General output-port register value |
| pwr_off_o | output | 1 | One-cycle shutdown request |

## Verification
Every result of this block is due exactly one clock after the edge that samples its cause:
- `irl_o` after a source change or a mask write;
- `rdata_o` after a read request;
- `pwr_off_o` after a qualifying write.

The bench drives its inputs on the falling edge and advances its behavioural model on the rising edge, using the inputs in place at that edge. It compares all four outputs on the next falling edge, so each expected value lines up with the single register stage. The directed phases cover each source alone, pairs whose levels and bit positions disagree, and masking of the winner. A long randomized phase mixes source toggles with accesses to every offset.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;
  localparam int NUM_SRC = 13;
  localparam int DW      = 16;
  localparam int AW      = 6;
  localparam int LW      = 4;
  localparam int NUM_LVL = 1 << LW;

  localparam logic [AW-1:0] OFS_MASK = 6'h00;
  localparam logic [AW-1:0] OFS_PWR  = 6'h30;
  localparam logic [AW-1:0] OFS_VER  = 6'h32;
  localparam logic [AW-1:0] OFS_OUT  = 6'h36;
  localparam logic [DW-1:0] VER_VAL  = 16'h0010;

  // status/mask bit used by source k
  function automatic int src_bit(input int k);
    case (k)
      0: return 9;   1: return 8;   2: return 14;  3: return 13;
      4: return 12;  5: return 11;  6: return 10;  7: return 6;
      8: return 5;   9: return 4;   10: return 7;  11: return 0;
      default: return 15;
    endcase
  endfunction

  // priority level of source k (0 = most urgent)
  function automatic int src_lvl(input int k);
    case (k)
      0: return 1;   1: return 2;   2: return 9;   3: return 10;
      4: return 3;   5: return 0;   6: return 4;   7: return 5;
      8: return 6;   9: return 7;   10: return 8;  11: return 11;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/bc_src_capture.sv
module bc_src_capture
  import board_ctl_pkg::*;
#(
  parameter int N = NUM_SRC,
  parameter int W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] status_d;

  always_comb begin
    status_d = '0;
    for (int k = 0; k < N; k++) status_d[src_bit(k)] = src_i[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= '0;
    else         status_o <= status_d;
  end
endmodule

// File: rtl/bc_irl_encoder.sv
module bc_irl_encoder
  import board_ctl_pkg::*;
#(
  parameter int N = NUM_SRC,
  parameter int W = DW,
  parameter int L = LW
) (
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic [L-1:0] irl_o
);
  localparam int NL = 1 << L;

  logic [W-1:0]  pend;
  logic [NL-1:0] lvl_hit;
  logic [L-1:0]  win;
  logic          any;

  assign pend = status_i & mask_i;

  // regroup pending bits by priority level
  always_comb begin
    lvl_hit = '0;
    for (int k = 0; k < N; k++)
      lvl_hit[src_lvl(k)] = lvl_hit[src_lvl(k)] | pend[src_bit(k)];
  end

  // lowest set level wins
  always_comb begin
    win = '1;
    any = 1'b0;
    for (int l = NL - 1; l >= 0; l--) begin
      if (lvl_hit[l]) begin
        win = L'(l);
        any = 1'b1;
      end
    end
  end

  assign irl_o = any ? (win ^ {L{1'b1}}) : '0;
endmodule

// File: rtl/bc_regs.sv
module bc_regs
  import board_ctl_pkg::*;
#(
  parameter int W = DW,
  parameter int A = AW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic         we_i,
  input  logic [A-1:0] addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] out_port_o,
  output logic         pwr_off_o
);
  logic wr, rd;
  logic [W-1:0] rd_val;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_comb begin
    unique case (addr_i)
      OFS_MASK: rd_val = mask_o;
      OFS_OUT:  rd_val = out_port_o;
      OFS_VER:  rd_val = VER_VAL;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o     <= '0;
      out_port_o <= '0;
      pwr_off_o  <= 1'b0;
      rdata_o    <= '0;
    end else begin
      pwr_off_o <= wr && (addr_i == OFS_PWR) && wdata_i[0];
      if (wr && addr_i == OFS_MASK) mask_o     <= wdata_i;
      if (wr && addr_i == OFS_OUT)  out_port_o <= wdata_i;
      if (rd)                       rdata_o    <= rd_val;
    end
  end
endmodule

// File: rtl/board_ctl.sv
module board_ctl
  import board_ctl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic [LW-1:0]      irl_o,
  output logic [DW-1:0]      out_port_o,
  output logic               pwr_off_o
);
  logic [DW-1:0] status;
  logic [DW-1:0] mask;

  bc_src_capture #(.N(NUM_SRC), .W(DW)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .status_o (status)
  );

  bc_regs #(.W(DW), .A(AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .mask_o     (mask),
    .out_port_o (out_port_o),
    .pwr_off_o  (pwr_off_o)
  );

  // fed only by registers, so irl_o moves one clock after its cause
  bc_irl_encoder #(.N(NUM_SRC), .W(DW), .L(LW)) u_enc (
    .status_i (status),
    .mask_i   (mask),
    .irl_o    (irl_o)
  );
endmodule

// File: rtl/bc_checker.sv
module bc_checker
  import board_ctl_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_i,
  input logic               req_i,
  input logic               we_i,
  input logic [AW-1:0]      addr_i,
  input logic [DW-1:0]      wdata_i,
  input logic [DW-1:0]      rdata_o,
  input logic [LW-1:0]      irl_o,
  input logic [DW-1:0]      out_port_o,
  input logic               pwr_off_o
);
  logic mapped;
  assign mapped = (addr_i == OFS_MASK) || (addr_i == OFS_OUT) ||
                  (addr_i == OFS_VER)  || (addr_i == OFS_PWR);

  // R7
  pwr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_off_o == $past(req_i && we_i && addr_i == OFS_PWR && wdata_i[0]));

  // R8
  ver_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == OFS_VER) |=> (rdata_o == VER_VAL));

  // R9
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !mapped) |=> (rdata_o == '0));

  // R6
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && addr_i == OFS_OUT) |=> $stable(out_port_o));

  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));

  // R1
  idle_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |=> (irl_o == '0));

  // R2
  mask_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFS_MASK && wdata_i == '0) |=> (irl_o == '0));
endmodule

bind board_ctl bc_checker u_bc_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_i      (src_i),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .irl_o      (irl_o),
  .out_port_o (out_port_o),
  .pwr_off_o  (pwr_off_o)
);

// File: tb/tb_board_ctl.sv
`timescale 1ns/1ps
module tb_board_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] src = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  irl;
  logic [15:0] out_port;
  logic        pwr;

  int checks = 0;
  int errors = 0;

  // per-source encodings from R1 and R3
  int bitpos [13] = '{9, 8, 14, 13, 12, 11, 10, 6, 5, 4, 7, 0, 15};
  int level  [13] = '{1, 2, 9, 10, 3, 0, 4, 5, 6, 7, 8, 11, 12};

  always #2.5 clk = ~clk;

  board_ctl dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irl_o(irl),
    .out_port_o(out_port), .pwr_off_o(pwr)
  );

  // behavioural model, advanced on the sampling edge
  logic [15:0] m_mask, m_out, m_stat, m_rdata;
  logic        m_pwr;
  logic [3:0]  m_irl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 0; m_out = 0; m_stat = 0; m_rdata = 0; m_pwr = 0; m_irl = 0;
    end else begin
      int best;
      m_pwr = 0;
      if (req && !we) begin
        if (addr == 6'h00)      m_rdata = m_mask;
        else if (addr == 6'h36) m_rdata = m_out;
        else if (addr == 6'h32) m_rdata = 16'h0010;
        else                    m_rdata = 0;
      end
      if (req && we) begin
        if (addr == 6'h00) m_mask = wdata;
        if (addr == 6'h36) m_out = wdata;
        if (addr == 6'h30) m_pwr = wdata[0];
      end
      m_stat = 0;
      for (int k = 0; k < 13; k++) if (src[k]) m_stat[bitpos[k]] = 1'b1;
      best = 15;
      for (int k = 0; k < 13; k++)
        if (m_stat[bitpos[k]] && m_mask[bitpos[k]] && level[k] < best) best = level[k];
      m_irl = 4'(best ^ 15);
    end
  end

  task automatic chk(input string req_tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req_tag, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    chk("R3/R4 irl_o", {12'h0, irl}, {12'h0, m_irl});
    chk("R6 out_port_o", out_port, m_out);
    chk("R7 pwr_off_o", {15'h0, pwr}, {15'h0, m_pwr});
    chk("R11 rdata_o", rdata, m_rdata);
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [5:0] a);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0;
  endtask

  task automatic set_src(input logic [12:0] s);
    @(negedge clk); src = s;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 irl", {12'h0, irl}, 16'h0);
    chk("R10 rdata", rdata, 16'h0);
    chk("R10 out_port", out_port, 16'h0);
    chk("R10 pwr", {15'h0, pwr}, 16'h0);
    rst_n = 1'b1;
    // R1/R2: sources ignored while masked off
    set_src(13'h1fff);
    chk("R2 masked irl", {12'h0, irl}, 16'h0);
    // R5
    wr(6'h00, 16'hffff);
    rd(6'h00);
    chk("R5 mask readback", rdata, 16'hffff);
    // R3: level-0 source wins over everything
    chk("R3 level0", {12'h0, irl}, 16'h000f);
    // each source alone
    for (int k = 0; k < 13; k++) begin
      set_src(13'(1 << k));
      chk("R1/R3 single", {12'h0, irl}, 16'(level[k] ^ 15));
    end
    // pair: bit 14 (lvl 9) vs bit 0 (lvl 11)
    set_src(13'h0804);
    chk("R3 pair", {12'h0, irl}, 16'(9 ^ 15));
    // R2: mask the winner, next-best appears
    wr(6'h00, 16'hbfff);
    chk("R2 mask winner", {12'h0, irl}, 16'(11 ^ 15));
    set_src(13'h0);
    chk("R3 none", {12'h0, irl}, 16'h0);
    // R6
    wr(6'h36, 16'ha5c3);
    chk("R6 out", out_port, 16'ha5c3);
    rd(6'h36);
    chk("R6 readback", rdata, 16'ha5c3);
    // R8
    wr(6'h32, 16'h1234);
    rd(6'h32);
    chk("R8 version", rdata, 16'h0010);
    // R7
    wr(6'h30, 16'h0002);
    wr(6'h30, 16'h0001);
    rd(6'h30);
    chk("R7 read zero", rdata, 16'h0);
    // R9: unmapped and odd addresses
    wr(6'h01, 16'h0000);
    wr(6'h37, 16'h0000);
    wr(6'h3e, 16'hffff);
    rd(6'h00);
    chk("R9 mask untouched", rdata, 16'hbfff);
    rd(6'h37);
    chk("R9 odd read", rdata, 16'h0);
    rd(6'h36);
    chk("R9 out untouched", rdata, 16'ha5c3);
    // randomized phase, model compares every cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) src = 13'($urandom);
      req = 1'($urandom);
      we = 1'($urandom);
      case ($urandom_range(0, 5))
        0: addr = 6'h00; 1: addr = 6'h30; 2: addr = 6'h32;
        3: addr = 6'h36; 4: addr = 6'($urandom) | 6'h01;
        default: addr = 6'($urandom);
      endcase
      wdata = 16'($urandom);
    end
    @(negedge clk); req = 0;
    repeat (3) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule